// File: doc/BRIEF.md
# Configurable Lookup-Table Logic Cell

This block models a single cell of a programmable logic fabric. A small one-bit-wide memory, the lookup table, holds the truth table of whatever function the cell should compute. The table is filled through a serial configuration port while the chip comes up. Until that load is complete, every output of the cell stays at zero.

After configuration, a mode input selects how the cell behaves. In logic mode the cell produces an arbitrary function of its four data inputs. In arithmetic mode it forms one bit of a sum and a carry towards the next cell. The lower half of the table supplies the sum and the upper half supplies the carry, both addressed by two operand bits and the incoming carry.

The result can pass straight out or go through a flip-flop. The flip-flop has an asynchronous clear, a synchronous clear, a synchronous load of a dedicated data bit, and a clock enable. Instead of the lookup result, the flip-flop can take a chain input from a neighbouring cell. This lets neighbouring registers form a shift path.

Top module: `lut_cell`

## Requirements
- R1: Configuration shifts one bit per clock while `cfg_en` is high. The first bit accepted lands at table address 0 and the k-th at address k-1. `cfg_done` goes high in the cycle after the sixteenth bit is accepted.
- R2: While `cfg_done` is low, `comb_out`, `carry_out`, `reg_out` and `cell_out` are all 0. The register ignores `sclr`, `sload` and `ena`.
- R3: Once `cfg_done` is high, `cfg_en` and `cfg_bit` have no effect on the table until `rst_n` is asserted again.
- R4: In logic mode (`arith_mode`=0), `comb_out` equals the table entry at address `din`, with `din[0]` as the address LSB. `carry_out` is 0.
- R5: In arithmetic mode (`arith_mode`=1), let i = {`carry_in`,`din[1]`,`din[0]`}. Then `comb_out` is table entry i and `carry_out` is table entry 8+i. `din[3:2]` have no effect.
- R6: `aclr` high forces `reg_out` to 0 at once, with no clock edge needed, and overrides every other register control.
- R7: At a clock edge after configuration, `sclr` clears the register. Otherwise `sload` loads `sload_d`. Both act whatever `ena` is.
- R8: With `sclr` and `sload` low, `ena` high captures the register's data source and `ena` low holds the register.
- R9: With `chain_sel` high the register's data source is `chain_in`; otherwise it is `comb_out`. Feeding `chain_in` from a neighbour's `reg_out` delays it by one clock.
- R10: `cell_out` equals `reg_out` when `out_sel` is 1 and `comb_out` when it is 0.
- R11: `rst_n` low clears the table, the configuration count, `cfg_done` and the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the whole cell |
| cfg_en | input | 1 | Configuration shift strobe |
| cfg_bit | input | 1 | Serial configuration data |
| cfg_done | output | 1 | Table fully loaded |
| din | input | 4 | Lookup address / operand bits |
| arith_mode | input | 1 | 1 selects arithmetic mode |
| carry_in | input | 1 | Carry from the previous cell |
| carry_out | output | 1 | Carry to the next cell |
| aclr | input | 1 | Asynchronous register clear |
| sclr | input | 1 | Synchronous register clear |
| sload | input | 1 | Synchronous load strobe |
| sload_d | input | 1 | Data for synchronous load |
| ena | input | 1 | Register clock enable |
| chain_sel | input | 1 | Register takes chain_in instead of the lookup result |
| chain_in | input | 1 | Register-chain input from the previous cell |
| out_sel | input | 1 | 1 routes the register to cell_out |
| comb_out | output | 1 | Combinational result |
| reg_out | output | 1 | Registered result, also the chain output |
| cell_out | output | 1 | Selected result |

## Verification
A wrong table bit appears on `comb_out` as soon as the inputs address it. In arithmetic mode it can appear on `carry_out` instead, in the same cycle. This is why the bench sweeps every address after each load. A slip in the shift order or in the bit count shows up either as a permuted truth table or as `cfg_done` rising one cycle early or late. A wrong register priority is visible on `reg_out` one edge after the conflicting controls. A broken asynchronous clear is visible before the next edge arrives.

// File: rtl/lut_cell_pkg.sv
package lut_cell_pkg;
   typedef enum logic {
      MODE_LOGIC = 1'b0,
      MODE_ARITH = 1'b1
   } cell_mode_e;

   typedef struct packed {
      logic sclr;
      logic sload;
      logic sload_d;
      logic ena;
      logic chain_sel;
      logic chain_in;
   } reg_ctrl_t;
endpackage

// File: rtl/lut_cfg_store.sv
module lut_cfg_store #(
   parameter int TBL_BITS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_en,
   input  logic                cfg_bit,
   output logic [TBL_BITS-1:0] table_q,
   output logic                loaded
);
   localparam int CNT_W = $clog2(TBL_BITS + 1);

   logic [CNT_W-1:0] cnt_q;

   assign loaded = (cnt_q == CNT_W'(TBL_BITS));

   // First accepted bit travels down to index 0 after TBL_BITS shifts.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         table_q <= '0;
         cnt_q   <= '0;
      end else if (cfg_en && !loaded) begin
         table_q <= {cfg_bit, table_q[TBL_BITS-1:1]};
         cnt_q   <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/lut_cell_eval.sv
module lut_cell_eval
   import lut_cell_pkg::*;
#(
   parameter int K = 4
) (
   input  logic [(1<<K)-1:0] table_q,
   input  logic [K-1:0]      din,
   input  cell_mode_e        mode,
   input  logic              carry_in,
   output logic              fn,
   output logic              carry
);
   localparam int TBL_BITS = 1 << K;
   localparam int HALF     = TBL_BITS / 2;

   logic [2:0]   op_idx;
   logic [K-1:0] sum_addr;
   logic [K-1:0] car_addr;

   assign op_idx   = {carry_in, din[1], din[0]};
   assign sum_addr = K'(op_idx);
   assign car_addr = K'(HALF) | K'(op_idx);

   always_comb begin
      if (mode == MODE_ARITH) begin
         fn    = table_q[sum_addr];
         carry = table_q[car_addr];
      end else begin
         fn    = table_q[din];
         carry = 1'b0;
      end
   end
endmodule

// File: rtl/lut_cell_reg.sv
module lut_cell_reg
   import lut_cell_pkg::*;
(
   input  logic      clk,
   input  logic      rst_n,
   input  logic      aclr,
   input  logic      live,
   input  reg_ctrl_t ctl,
   input  logic      fn,
   output logic      q
);
   logic d_src;

   assign d_src = ctl.chain_sel ? ctl.chain_in : fn;

   always_ff @(posedge clk or negedge rst_n or posedge aclr) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else if (aclr) begin
         q <= 1'b0;
      end else if (live) begin
         if (ctl.sclr)       q <= 1'b0;
         else if (ctl.sload) q <= ctl.sload_d;
         else if (ctl.ena)   q <= d_src;
      end
   end
endmodule

// File: rtl/lut_cell.sv
module lut_cell
   import lut_cell_pkg::*;
#(
   parameter int K = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         cfg_en,
   input  logic         cfg_bit,
   output logic         cfg_done,
   input  logic [K-1:0] din,
   input  logic         arith_mode,
   input  logic         carry_in,
   output logic         carry_out,
   input  logic         aclr,
   input  logic         sclr,
   input  logic         sload,
   input  logic         sload_d,
   input  logic         ena,
   input  logic         chain_sel,
   input  logic         chain_in,
   input  logic         out_sel,
   output logic         comb_out,
   output logic         reg_out,
   output logic         cell_out
);
   localparam int TBL_BITS = 1 << K;

   generate
      if (K < 4 || K > 8) begin : g_bad_k
         $error("lut_cell: K must lie in 4..8");
      end
   endgenerate

   logic [TBL_BITS-1:0] table_q;
   logic                loaded;
   logic                fn;
   logic                carry;
   logic                q;
   reg_ctrl_t           ctl;
   cell_mode_e          mode;

   assign mode = cell_mode_e'(arith_mode);
   assign ctl  = '{sclr: sclr, sload: sload, sload_d: sload_d, ena: ena,
                   chain_sel: chain_sel, chain_in: chain_in};

   lut_cfg_store #(.TBL_BITS(TBL_BITS)) u_store (
      .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
      .table_q(table_q), .loaded(loaded)
   );

   lut_cell_eval #(.K(K)) u_eval (
      .table_q(table_q), .din(din), .mode(mode), .carry_in(carry_in),
      .fn(fn), .carry(carry)
   );

   lut_cell_reg u_reg (
      .clk(clk), .rst_n(rst_n), .aclr(aclr), .live(loaded),
      .ctl(ctl), .fn(comb_out), .q(q)
   );

   assign cfg_done  = loaded;
   assign comb_out  = loaded & fn;
   assign carry_out = loaded & carry;
   assign reg_out   = q;
   assign cell_out  = out_sel ? reg_out : comb_out;
endmodule

// File: rtl/lut_cell_chk.sv
module lut_cell_chk (
   input logic clk,
   input logic rst_n,
   input logic cfg_done,
   input logic arith_mode,
   input logic carry_out,
   input logic aclr,
   input logic sclr,
   input logic sload,
   input logic sload_d,
   input logic ena,
   input logic comb_out,
   input logic reg_out
);
   // R2
   unconfig_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_done |-> (!comb_out && !reg_out && !carry_out));

   // R3
   cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_done |=> cfg_done);

   // R4
   logic_no_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !arith_mode |-> !carry_out);

   // R6
   aclr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      aclr |-> !reg_out);

   // R7
   sclr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n || aclr)
      (cfg_done && sclr) |=> !reg_out);

   // R7
   sload_take_chk: assert property (@(posedge clk) disable iff (!rst_n || aclr)
      (cfg_done && !sclr && sload) |=> (reg_out == $past(sload_d)));

   // R8
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n || aclr)
      (cfg_done && !sclr && !sload && !ena) |=> $stable(reg_out));
endmodule

bind lut_cell lut_cell_chk u_chk (.*);

// File: tb/lut_cell_test.sv
`timescale 1ns/1ps
module lut_cell_test;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_en = 0, cfg_bit = 0, cfg_done;
   logic [3:0] din = 0;
   logic arith_mode = 0, carry_in = 0, carry_out;
   logic aclr = 0, sclr = 0, sload = 0, sload_d = 0, ena = 0;
   logic chain_sel = 0, chain_in = 0, out_sel = 0;
   logic comb_out, reg_out, cell_out;

   int checks = 0;
   int errors = 0;
   bit finished = 0;
   logic [15:0] tbl_m;
   logic q_m;

   always #2.5 clk = ~clk;

   lut_cell uut (.*);

   function automatic logic f_comb(logic [15:0] t, logic [3:0] a, logic m, logic c);
      return m ? t[{1'b0, c, a[1], a[0]}] : t[a];
   endfunction

   function automatic logic f_carry(logic [15:0] t, logic [3:0] a, logic m, logic c);
      return m ? t[{1'b1, c, a[1], a[0]}] : 1'b0;
   endfunction

   task automatic chk(string req, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
      end
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; cfg_en = 0; aclr = 0; sclr = 0; sload = 0; ena = 0;
      @(negedge clk);
      rst_n = 1;
      q_m = 0;
      #1 chk("R11 cfg_done", cfg_done, 1'b0);
      chk("R11 reg_out", reg_out, 1'b0);
   endtask

   task automatic configure(logic [15:0] v);
      for (int k = 0; k < 16; k++) begin
         @(negedge clk);
         cfg_en = 1; cfg_bit = v[k];
         if (k == 15) begin
            #1 chk("R1 done early", cfg_done, 1'b0);
         end
      end
      @(negedge clk);
      cfg_en = 0;
      #1 chk("R1 done", cfg_done, 1'b1);
      tbl_m = v;
   endtask

   task automatic sweep(string req);
      for (int m = 0; m < 2; m++)
         for (int a = 0; a < 32; a++) begin
            @(negedge clk);
            din = a[3:0]; carry_in = a[4]; arith_mode = m[0]; out_sel = 0;
            #1;
            chk({req, " R4/R5 comb"}, comb_out, f_comb(tbl_m, din, arith_mode, carry_in));
            chk({req, " R4/R5 carry"}, carry_out, f_carry(tbl_m, din, arith_mode, carry_in));
            chk({req, " R10 cell"}, cell_out, comb_out);
         end
      arith_mode = 0;
   endtask

   task automatic step();
      logic src;
      @(negedge clk);
      din = 4'($urandom); arith_mode = 1'($urandom); carry_in = 1'($urandom);
      aclr = ($urandom % 20) == 0; sclr = ($urandom % 12) == 0;
      sload = ($urandom % 6) == 0; sload_d = 1'($urandom);
      ena = 1'($urandom); chain_sel = ($urandom % 4) == 0; chain_in = 1'($urandom);
      out_sel = 1'($urandom);
      #1;
      if (aclr) q_m = 0;
      chk("R6/R8 reg_out", reg_out, q_m);
      chk("R4/R5 comb_out", comb_out, f_comb(tbl_m, din, arith_mode, carry_in));
      chk("R5 carry_out", carry_out, f_carry(tbl_m, din, arith_mode, carry_in));
      chk("R10 cell_out", cell_out, out_sel ? q_m : f_comb(tbl_m, din, arith_mode, carry_in));
      src = chain_sel ? chain_in : f_comb(tbl_m, din, arith_mode, carry_in);
      @(posedge clk);
      if (aclr) q_m = 0;
      else if (sclr) q_m = 0;
      else if (sload) q_m = sload_d;
      else if (ena) q_m = src;
      #1 chk("R7/R8/R9 reg_out", reg_out, q_m);
   endtask

   initial begin
      #(5.0 * 150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [15:0] v;
      void'($urandom(32'h5eed_1234));
      do_reset();

      // R2: half-configured cell stays silent and register ignores controls
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); cfg_en = 1; cfg_bit = 1;
      end
      @(negedge clk);
      cfg_en = 0; din = 4'hF; sload = 1; sload_d = 1; ena = 1; out_sel = 1;
      @(posedge clk); #1;
      chk("R2 comb_out", comb_out, 1'b0);
      chk("R2 reg_out", reg_out, 1'b0);
      chk("R2 cell_out", cell_out, 1'b0);
      @(negedge clk); sload = 0; ena = 0; out_sel = 0;

      // R1/R4/R5: full adder table, sum lower half, majority upper half
      do_reset();
      configure(16'b1110_1000_1001_0110);
      sweep("fa");

      // R3: further configuration attempts ignored
      for (int k = 0; k < 16; k++) begin
         @(negedge clk); cfg_en = 1; cfg_bit = ~tbl_m[k];
      end
      @(negedge clk); cfg_en = 0;
      sweep("R3 locked");

      // R6: asynchronous clear before any edge
      @(negedge clk); sload = 1; sload_d = 1;
      @(posedge clk); #1 chk("R7 sload", reg_out, 1'b1);
      @(negedge clk); sload = 0; #1 aclr = 1; #0.5;
      chk("R6 async", reg_out, 1'b0);
      @(negedge clk); aclr = 0;

      // R7: sclr beats sload, sload without ena
      @(negedge clk); sload = 1; sload_d = 1; ena = 0;
      @(posedge clk); #1 chk("R7 sload no ena", reg_out, 1'b1);
      @(negedge clk); sclr = 1;
      @(posedge clk); #1 chk("R7 sclr priority", reg_out, 1'b0);
      @(negedge clk); sclr = 0; sload = 0;

      // R9: shift path via chain_in
      v = 16'hB2D4;
      chain_sel = 1; ena = 1;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk); chain_in = v[k];
         @(posedge clk); #1 chk("R9 chain", reg_out, v[k]);
      end
      @(negedge clk); chain_sel = 0; ena = 0;
      q_m = reg_out;

      // random tables and control mixes
      for (int r = 0; r < 4; r++) begin
         do_reset();
         configure(16'($urandom));
         sweep("rand");
         for (int s = 0; s < 300; s++) step();
         @(negedge clk); aclr = 0;
      end

      finish_run();
   end
endmodule